// File: doc/BRIEF.md
# Register-controlled watchdog timer

This block is a watchdog that a host drives through a byte-wide register port: one 8-bit address, one 8-bit write data bus with a write strobe, and a combinational read data bus. The host programs a timeout in whole seconds and a reset-pulse width in milliseconds. It then switches the run state to "on" and keeps writing a zero to the ping register. If no ping arrives before the seconds run out, the block drives its reset output high for the programmed number of milliseconds. It records the expiry as the reset cause and falls back to the unconfigured run state.

Milliseconds and seconds come from a prescaler off the system clock, set by two parameters. The second phase restarts on every reload, so the time-left readback is exact to the cycle. The run state has three values. The power-up value 0 ("unconfigured") is distinct from 1 ("off"), and only 2 ("on") counts. The state register, the timeout register and the ping register share the port with a time-left readback, the reset-cause code and the pulse-width register.

Top module: `regwdt`

## Requirements
- R1: After reset the run state reads 0, the timeout reads TIMEOUT_RST, the time-left register reads TIMEOUT_RST, the pulse width reads DUR_RST, the reset cause reads 0 (power cycle), and the reset output is low.
- R2: Address 0x06 holds the run state. Writes of 0, 1 and 2 are taken and any other value is ignored. Time-left counts down only in state 2, and in states 0 and 1 it holds its value.
- R3: Address 0x07 holds the timeout in seconds. A written value below 3 is stored as 3. A timeout write while in state 2 also loads time-left with the new value and restarts the second phase.
- R4: Writing 0 to address 0x09 while in state 2 loads time-left with the timeout and restarts the second phase. A nonzero ping value, or a ping in state 0 or 1, has no effect.
- R5: Address 0x08 returns the remaining whole seconds. n clock cycles after the edge that loads it with T, it reads T − floor(n / (CLK_PER_MS·MS_PER_SEC)).
- R6: When time-left would leave 1 on a second boundary, the same clock edge raises the reset output, sets the reset cause at address 0x05 to 1, sets the run state to 0 and sets time-left to 0.
- R7: The reset output stays high for exactly (pulse width in ms)·CLK_PER_MS clock cycles and then goes low.
- R8: Address 0x0A holds the pulse width in milliseconds (1 to 255). A write of 0 is ignored and the old width is kept.
- R9: While the reset output is high, writes of 0 or 1 to the run state are ignored.
- R10: Reads of the ping address and of any unmapped address, including 0x01 to 0x04, return 0.
- R11: A reload write (ping, timeout or state 2) that lands on the clock edge where expiry would happen takes priority, and no reset pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one write per asserted cycle |
| addr | input | 8 | Register address for both read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| wdt_rst_o | output | 1 | Reset pulse output, active high |

## Verification
The hardest case to reach from the ports is a collision between a reload write and the very edge on which the last second runs out. Stimulus gets there by counting cycles from the reload edge and issuing the ping so that its write edge lands exactly on the expiry edge. The constrained-random ping phase draws ping spacings from the whole window up to two cycles short of expiry, so second boundaries are crossed at every offset. A pulse is then allowed to start on purpose so that run-state writes can be issued during it and their rejection observed at the state readback.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [7:0] {
        ST_INIT = 8'd0,
        ST_OFF  = 8'd1,
        ST_ON   = 8'd2
    } run_e;

    localparam logic [7:0] A_CAUSE   = 8'h05;
    localparam logic [7:0] A_STATE   = 8'h06;
    localparam logic [7:0] A_TIMEOUT = 8'h07;
    localparam logic [7:0] A_LEFT    = 8'h08;
    localparam logic [7:0] A_PING    = 8'h09;
    localparam logic [7:0] A_WIDTH   = 8'h0A;

    localparam logic [7:0] CAUSE_POWER  = 8'd0;
    localparam logic [7:0] CAUSE_EXPIRY = 8'd1;

    localparam logic [7:0] TIMEOUT_FLOOR = 8'd3;

    typedef struct packed {
        run_e       state;
        logic [7:0] timeout;
        logic [7:0] left;
        logic [7:0] width;
        logic [7:0] cause;
    } wdt_regs_t;

endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
    parameter int CLK_PER_MS = 50000,
    parameter int MS_PER_SEC = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic sec_tick
);
    localparam int CW = $clog2(CLK_PER_MS + 1);
    localparam int MW = $clog2(MS_PER_SEC + 1);
    localparam logic [CW-1:0] CYC_LAST = CW'(CLK_PER_MS - 1);
    localparam logic [MW-1:0] MS_LAST  = MW'(MS_PER_SEC - 1);

    typedef struct packed {
        logic [CW-1:0] cyc;
        logic [MW-1:0] ms;
    } tick_t;

    tick_t d, q;
    logic  ms_wrap;

    always_comb begin
        d        = q;
        ms_wrap  = (q.cyc == CYC_LAST);
        sec_tick = !restart && ms_wrap && (q.ms == MS_LAST);
        if (restart) begin
            d = '0;
        end else if (ms_wrap) begin
            d.cyc = '0;
            d.ms  = (q.ms == MS_LAST) ? '0 : q.ms + 1'b1;
        end else begin
            d.cyc = q.cyc + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R5: the sub-millisecond and millisecond counters stay in range
    p_cyc_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cyc <= CYC_LAST) && (q.ms <= MS_LAST));

endmodule

// File: rtl/wdt_pulse_gen.sv
module wdt_pulse_gen #(
    parameter int CLK_PER_MS = 50000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] len_ms,
    output logic       active
);
    localparam int CW = $clog2(CLK_PER_MS + 1);
    localparam logic [CW-1:0] CYC_LAST = CW'(CLK_PER_MS - 1);

    typedef struct packed {
        logic          act;
        logic [7:0]    ms_left;
        logic [CW-1:0] cyc;
    } pulse_t;

    pulse_t d, q;

    always_comb begin
        d = q;
        if (start) begin
            d.act     = 1'b1;
            d.ms_left = len_ms;
            d.cyc     = '0;
        end else if (q.act) begin
            if (q.cyc == CYC_LAST) begin
                d.cyc     = '0;
                d.ms_left = q.ms_left - 8'd1;
                if (q.ms_left == 8'd1) d.act = 1'b0;
            end else begin
                d.cyc = q.cyc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign active = q.act;

    // R7: an active pulse always has milliseconds left to run
    p_pulse_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.act |-> (q.ms_left != 8'd0));

    // R8: a pulse is never started with a zero length
    p_len_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (len_ms != 8'd0));

endmodule

// File: rtl/regwdt.sv
module regwdt #(
    parameter int CLK_PER_MS  = 50000,
    parameter int MS_PER_SEC  = 1000,
    parameter int TIMEOUT_RST = 60,
    parameter int DUR_RST     = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       wdt_rst_o
);
    import wdt_pkg::*;

    localparam logic [7:0] TO_INIT = (TIMEOUT_RST < 3) ? 8'd3 :
                                     (TIMEOUT_RST > 255) ? 8'd255 : 8'(TIMEOUT_RST);
    localparam logic [7:0] W_INIT  = (DUR_RST < 1) ? 8'd1 :
                                     (DUR_RST > 255) ? 8'd255 : 8'(DUR_RST);

    wdt_regs_t  d, q;
    logic       sec_tick;
    logic       restart;
    logic       fire;
    logic       reload;
    logic       pulse_on;
    logic       st_ok, to_wr, ping_ok, touch;
    logic [7:0] to_clamped;

    always_comb begin
        d          = q;
        fire       = 1'b0;
        reload     = 1'b0;
        to_clamped = (wdata < TIMEOUT_FLOOR) ? TIMEOUT_FLOOR : wdata;
        st_ok      = wr_en && (addr == A_STATE) &&
                     ((wdata == ST_ON) || ((wdata < 8'd2) && !pulse_on));
        to_wr      = wr_en && (addr == A_TIMEOUT);
        ping_ok    = wr_en && (addr == A_PING) && (wdata == 8'd0) && (q.state == ST_ON);
        touch      = st_ok || ping_ok || (to_wr && (q.state == ST_ON));

        // countdown and expiry, overridden by any host reload or state change
        if ((q.state == ST_ON) && sec_tick && !touch) begin
            if (q.left == 8'd1) begin
                d.left  = 8'd0;
                d.state = ST_INIT;
                d.cause = CAUSE_EXPIRY;
                fire    = 1'b1;
            end else begin
                d.left = q.left - 8'd1;
            end
        end

        if (to_wr) begin
            d.timeout = to_clamped;
            if (q.state == ST_ON) begin
                d.left = to_clamped;
                reload = 1'b1;
            end
        end
        if (st_ok) begin
            d.state = run_e'(wdata);
            if (wdata == ST_ON) begin
                d.left = q.timeout;
                reload = 1'b1;
            end
        end
        if (ping_ok) begin
            d.left = q.timeout;
            reload = 1'b1;
        end
        if (wr_en && (addr == A_WIDTH) && (wdata != 8'd0)) begin
            d.width = wdata;
        end

        restart = (q.state != ST_ON) || reload;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state   <= ST_INIT;
            q.timeout <= TO_INIT;
            q.left    <= TO_INIT;
            q.width   <= W_INIT;
            q.cause   <= CAUSE_POWER;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        case (addr)
            A_CAUSE:   rdata = q.cause;
            A_STATE:   rdata = q.state;
            A_TIMEOUT: rdata = q.timeout;
            A_LEFT:    rdata = q.left;
            A_WIDTH:   rdata = q.width;
            default:   rdata = 8'd0;
        endcase
    end

    wdt_tick_gen #(
        .CLK_PER_MS (CLK_PER_MS),
        .MS_PER_SEC (MS_PER_SEC)
    ) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (restart),
        .sec_tick (sec_tick)
    );

    wdt_pulse_gen #(
        .CLK_PER_MS (CLK_PER_MS)
    ) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (fire),
        .len_ms (q.width),
        .active (pulse_on)
    );

    assign wdt_rst_o = pulse_on;

    // R3: the stored timeout never drops under the floor
    p_timeout_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q.timeout >= TIMEOUT_FLOOR);

    // R8: the stored pulse width is never zero
    p_width_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q.width != 8'd0);

    // R5: while counting, time-left is between 1 and the timeout
    p_on_left_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_ON) |-> ((q.left != 8'd0) && (q.left <= q.timeout)));

    // R2: outside the on state and without a state write, time-left holds
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.state != ST_ON) && !(wr_en && (addr == A_STATE))) |=> $stable(q.left));

    // R4: an accepted ping loads the timeout into time-left
    p_ping_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == A_PING) && (wdata == 8'd0) && (q.state == ST_ON))
        |=> (q.left == $past(q.timeout)));

    // R6: a fresh reset pulse comes with the expiry cause and the initial state
    p_pulse_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_rst_o) |-> ((q.cause == CAUSE_EXPIRY) && (q.state == ST_INIT)
                              && (q.left == 8'd0)));

    // R9: state writes of 0 or 1 during the pulse leave the state alone
    p_pulse_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_rst_o && wr_en && (addr == A_STATE) && (wdata < 8'd2) && (q.state != ST_ON))
        |=> $stable(q.state));

endmodule

// File: tb/tb_regwdt.sv
`timescale 1ns/1ps
module tb_regwdt;

    localparam int CPM  = 4;
    localparam int MPS  = 4;
    localparam int P    = CPM * MPS;
    localparam int TRST = 5;
    localparam int WRST = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] addr = 8'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       wdt_rst_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int tref = 0;
    bit done = 1'b0;

    regwdt #(
        .CLK_PER_MS  (CPM),
        .MS_PER_SEC  (MPS),
        .TIMEOUT_RST (TRST),
        .DUR_RST     (WRST)
    ) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .wdt_rst_o (wdt_rst_o)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int exp_left(input int t, input int n);
        if (n >= t * P) return 0;
        return t - n / P;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // called at a falling edge; the write lands on the next rising edge
    task automatic wr(input logic [7:0] a, input logic [7:0] v);
        wr_en = 1'b1;
        addr  = a;
        wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output int v);
        addr = a;
        #1;
        v = int'(rdata);
    endtask

    task automatic wait_n(input int n);
        while (cyc - tref < n) @(negedge clk);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int v;
        int t;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values
        rd(8'h06, v); chk("R1 state", v, 0);
        rd(8'h07, v); chk("R1 timeout", v, TRST);
        rd(8'h08, v); chk("R1 left", v, TRST);
        rd(8'h0A, v); chk("R1 width", v, WRST);
        rd(8'h05, v); chk("R1 cause", v, 0);
        chk("R1 rst_o", int'(wdt_rst_o), 0);

        // R10: unmapped and ping reads
        rd(8'h01, v); chk("R10 addr01", v, 0);
        rd(8'h04, v); chk("R10 addr04", v, 0);
        rd(8'h09, v); chk("R10 ping read", v, 0);

        // R2: no counting in the unconfigured state
        repeat (100) @(negedge clk);
        rd(8'h08, v); chk("R2 init hold", v, TRST);
        chk("R2 init no pulse", int'(wdt_rst_o), 0);

        // R3: clamp and store
        wr(8'h07, 8'd1);   rd(8'h07, v); chk("R3 clamp 1", v, 3);
        wr(8'h07, 8'd0);   rd(8'h07, v); chk("R3 clamp 0", v, 3);
        wr(8'h07, 8'd255); rd(8'h07, v); chk("R3 max", v, 255);
        wr(8'h07, 8'd7);   rd(8'h07, v); chk("R3 seven", v, 7);
        rd(8'h08, v); chk("R3 no reload when not on", v, TRST);

        // R8: zero width ignored
        wr(8'h0A, 8'd0); rd(8'h0A, v); chk("R8 zero ignored", v, WRST);
        wr(8'h0A, 8'd3); rd(8'h0A, v); chk("R8 width 3", v, 3);

        // R2: off state and illegal state value
        wr(8'h06, 8'd1); rd(8'h06, v); chk("R2 off", v, 1);
        wr(8'h06, 8'd5); rd(8'h06, v); chk("R2 bad value ignored", v, 1);
        wr(8'h09, 8'd0);
        repeat (50) @(negedge clk);
        rd(8'h08, v); chk("R4 ping while off no effect", v, TRST);

        // R5: countdown after entering on with timeout 7
        wr(8'h06, 8'd2); tref = cyc;
        rd(8'h08, v); chk("R5 load", v, 7);
        wait_n(P - 1); rd(8'h08, v); chk("R5 before boundary", v, exp_left(7, P - 1));
        wait_n(P);     rd(8'h08, v); chk("R5 at boundary", v, exp_left(7, P));
        wait_n(3 * P + 5); rd(8'h08, v); chk("R5 mid", v, exp_left(7, 3 * P + 5));

        // R4: nonzero ping ignored
        wr(8'h09, 8'd3);
        rd(8'h08, v); chk("R4 nonzero ping ignored", v, exp_left(7, cyc - tref));
        wr(8'h09, 8'd0); tref = cyc;
        rd(8'h08, v); chk("R4 ping reload", v, 7);

        // R3: timeout write while on reloads and restarts the second phase
        wait_n(20);
        wr(8'h07, 8'd6); tref = cyc;
        rd(8'h08, v); chk("R3 reload on write", v, 6);
        wait_n(P - 1); rd(8'h08, v); chk("R3 phase restart", v, exp_left(6, P - 1));
        wait_n(P);     rd(8'h08, v); chk("R3 phase boundary", v, exp_left(6, P));

        // R4/R5: random ping spacing with timeout 4
        wr(8'h07, 8'd4); tref = cyc;
        t = 4;
        for (int i = 0; i < 16; i++) begin
            int dly;
            dly = 1 + int'($urandom % (t * P - 2));
            wait_n(dly);
            rd(8'h08, v); chk("R5 random left", v, exp_left(t, dly));
            chk("R4 no pulse while pinged", int'(wdt_rst_o), 0);
            wr(8'h09, 8'd0); tref = cyc;
        end

        // R11: ping landing on the expiry edge wins
        wait_n(t * P - 1);
        wr(8'h09, 8'd0); tref = cyc;
        chk("R11 no pulse", int'(wdt_rst_o), 0);
        rd(8'h08, v); chk("R11 reloaded", v, t);
        rd(8'h06, v); chk("R11 still on", v, 2);

        // R6/R7/R9: expiry and pulse
        wait_n(t * P - 1);
        chk("R6 low before expiry", int'(wdt_rst_o), 0);
        rd(8'h08, v); chk("R6 last second", v, 1);
        wait_n(t * P);
        chk("R6 pulse rises", int'(wdt_rst_o), 1);
        rd(8'h05, v); chk("R6 cause", v, 1);
        rd(8'h06, v); chk("R6 state init", v, 0);
        rd(8'h08, v); chk("R6 left zero", v, 0);
        wr(8'h06, 8'd1);
        rd(8'h06, v); chk("R9 off ignored in pulse", v, 0);
        wr(8'h06, 8'd0);
        rd(8'h06, v); chk("R9 init write in pulse", v, 0);
        wait_n(t * P + 3 * CPM - 1);
        chk("R7 still high", int'(wdt_rst_o), 1);
        wait_n(t * P + 3 * CPM);
        chk("R7 pulse ended", int'(wdt_rst_o), 0);
        wr(8'h06, 8'd1);
        rd(8'h06, v); chk("R9 accepted after pulse", v, 1);
        rd(8'h05, v); chk("R6 cause kept", v, 1);

        // R2: stopping while on freezes time-left
        wr(8'h06, 8'd2); tref = cyc;
        wait_n(P + 2);
        wr(8'h06, 8'd1);
        rd(8'h08, v); chk("R2 stop value", v, exp_left(t, P + 3));
        repeat (3 * P) @(negedge clk);
        rd(8'h08, v); chk("R2 off hold", v, exp_left(t, P + 3));
        chk("R2 off no pulse", int'(wdt_rst_o), 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule